// File: doc/BRIEF.md
# Three-Address Memory-to-Memory Processor

This block is a small sequential processor. Program and data share a single word-addressed memory. Each 32-bit instruction word carries a 5-bit opcode and three 9-bit addresses: two source operands and one destination. An arithmetic instruction reads both operands from memory, computes a sum, a difference or the low 32 bits of a product, and writes the value to the destination word and to a visible result register. A conditional jump chooses between two absolute targets from the sign of the result register. A halt instruction stops the core. A fixed budget of executed instructions also stops the core if no halt is reached.

A host loads a program through the memory port while the core is idle or finished. It then pulses `start` with an entry address and waits for `done`. After that it can read back memory through the same port, along with the result register, the executed-instruction count and the error flag.

The controller is a state machine over a single-port synchronous memory with one cycle of read latency. Its states are:

- IDLE: after reset. The host owns the memory.
- FETCH: the program counter is sent to the memory.
- DECODE: the instruction word arrives and is decoded.
- OPA: the first operand arrives and the second address is issued.
- OPB: the second operand arrives. The ALU result is written back and the program counter steps.
- DONE: stopped. The host owns the memory again.

Its transitions are:

- IDLE or DONE go to FETCH on `start`.
- FETCH goes to DECODE.
- DECODE goes to OPA for add, subtract or multiply.
- DECODE goes to FETCH for a jump while budget remains.
- DECODE goes to DONE for halt, for an undefined opcode, or for a jump that uses up the budget.
- OPA goes to OPB.
- OPB goes to FETCH while budget remains, and to DONE once it is used up.

Top module: `tri_addr_cpu`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `result` and `op_count` are all zero.
- R2: In IDLE or DONE, `host_we` writes `host_wdata` to `host_addr`, and `host_rdata` shows the word at `host_addr` one cycle after the address is applied. While `busy` is high, host writes are dropped.
- R3: An instruction word holds the opcode in bits 31:27, the first source address in bits 26:18, the second source address in bits 17:9 and the destination address in bits 8:0.
- R4: A `start` pulse in IDLE or DONE loads the program counter from `start_addr`, clears `result`, `op_count` and `err`, and raises `busy` on the next cycle.
- R5: Opcodes 1 (add), 2 (subtract: first minus second) and 3 (multiply, low 32 bits kept) write mem[src1] op mem[src2] to mem[dst] and to `result`, then continue at the program counter plus one.
- R6: Opcode 4 continues at src1 when `result`, taken as signed, is less than or equal to zero, and at src2 otherwise. It writes no memory.
- R7: Opcode 0 raises `done` and stops fetching.
- R8: Any opcode from 5 to 31 acts as a halt and also raises `err`.
- R9: `op_count` counts every executed instruction, halts included. When it reaches the budget (default 40), the core stops with `done` high and `err` low.
- R10: From the `start` edge, an arithmetic instruction takes 4 cycles, and a jump or a halt takes 2 cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution (honoured in IDLE or DONE) |
| start_addr | input | 9 | Entry address of the program |
| host_we | input | 1 | Host memory write enable |
| host_addr | input | 9 | Host memory address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Memory read data, one cycle after the address |
| busy | output | 1 | Core is executing |
| done | output | 1 | Core has stopped |
| err | output | 1 | Stopped on an undefined opcode |
| result | output | 32 | Last arithmetic result |
| op_count | output | 6 | Instructions executed since start |

## Verification
The assertions assume that `start` is pulsed only while the core is in IDLE or DONE. They also assume that host memory traffic matters only in those two states. The bench issues `start` only after `done`, or right after reset. Any host write it makes during execution is there only to show that the write is dropped. The assertions also assume that programs never need more than the budget to reach a halt, unless the run is testing the budget stop. The bench therefore sizes its countdown loops just below, exactly at and beyond the budget.

// File: rtl/tac_pkg.sv
package tac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_OPA,
        ST_OPB,
        ST_DONE
    } tac_state_e;

    localparam int OP_HALT = 0;
    localparam int OP_ADD  = 1;
    localparam int OP_SUB  = 2;
    localparam int OP_MUL  = 3;
    localparam int OP_JMP  = 4;

endpackage

// File: rtl/tac_ram.sv
module tac_ram #(
    parameter int DW = 32,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        rdata <= cells[addr];
    end
endmodule

// File: rtl/tac_alu.sv
module tac_alu #(
    parameter int DW = 32
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (sel)
            2'd2:    y = a - b;
            2'd3:    y = a * b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/tri_addr_cpu.sv
module tri_addr_cpu
    import tac_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 9,
    parameter int OP_BUDGET = 40,
    parameter int CNT_W     = $clog2(OP_BUDGET + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] result,
    output logic [CNT_W-1:0]  op_count
);
    localparam int OPC_LSB = 3 * ADDR_W;
    localparam int OPC_W   = DATA_W - OPC_LSB;
    localparam int SA_LSB  = 2 * ADDR_W;
    localparam int SB_LSB  = ADDR_W;
    localparam logic [CNT_W-1:0] BUDGET_C = CNT_W'(OP_BUDGET);
    localparam logic [OPC_W-1:0] K_HALT = OPC_W'(OP_HALT);
    localparam logic [OPC_W-1:0] K_ADD  = OPC_W'(OP_ADD);
    localparam logic [OPC_W-1:0] K_SUB  = OPC_W'(OP_SUB);
    localparam logic [OPC_W-1:0] K_MUL  = OPC_W'(OP_MUL);
    localparam logic [OPC_W-1:0] K_JMP  = OPC_W'(OP_JMP);

    tac_state_e          st, st_n;
    logic [ADDR_W-1:0]   pc, pc_n;
    logic [1:0]          k_sel, k_sel_n;
    logic [ADDR_W-1:0]   k_srcb, k_srcb_n, k_dst, k_dst_n;
    logic [DATA_W-1:0]   opa, opa_n, res_n;
    logic [CNT_W-1:0]    cnt_n, cnt_inc;
    logic                err_n;

    logic                ram_we;
    logic [ADDR_W-1:0]   ram_addr;
    logic [DATA_W-1:0]   ram_wdata, ram_rdata, alu_y;

    logic [OPC_W-1:0]    d_opc;
    logic [ADDR_W-1:0]   d_srca, d_srcb, d_dst;

    assign d_opc  = ram_rdata[DATA_W-1:OPC_LSB];
    assign d_srca = ram_rdata[OPC_LSB-1:SA_LSB];
    assign d_srcb = ram_rdata[SA_LSB-1:SB_LSB];
    assign d_dst  = ram_rdata[SB_LSB-1:0];
    assign cnt_inc = op_count + 1'b1;

    tac_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    tac_alu #(.DW(DATA_W)) u_alu (
        .sel (k_sel),
        .a   (opa),
        .b   (ram_rdata),
        .y   (alu_y)
    );

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            pc       <= '0;
            k_sel    <= '0;
            k_srcb   <= '0;
            k_dst    <= '0;
            opa      <= '0;
            result   <= '0;
            op_count <= '0;
            err      <= 1'b0;
        end else begin
            st       <= st_n;
            pc       <= pc_n;
            k_sel    <= k_sel_n;
            k_srcb   <= k_srcb_n;
            k_dst    <= k_dst_n;
            opa      <= opa_n;
            result   <= res_n;
            op_count <= cnt_n;
            err      <= err_n;
        end
    end

    // Next state, datapath updates and memory port steering
    always_comb begin
        st_n      = st;
        pc_n      = pc;
        k_sel_n   = k_sel;
        k_srcb_n  = k_srcb;
        k_dst_n   = k_dst;
        opa_n     = opa;
        res_n     = result;
        cnt_n     = op_count;
        err_n     = err;
        ram_we    = 1'b0;
        ram_addr  = host_addr;
        ram_wdata = host_wdata;
        unique case (st)
            ST_IDLE, ST_DONE: begin
                ram_we = host_we;
                if (start) begin
                    st_n  = ST_FETCH;
                    pc_n  = start_addr;
                    res_n = '0;
                    cnt_n = '0;
                    err_n = 1'b0;
                end
            end
            ST_FETCH: begin
                ram_addr = pc;
                st_n     = ST_DECODE;
            end
            ST_DECODE: begin
                k_sel_n  = d_opc[1:0];
                k_srcb_n = d_srcb;
                k_dst_n  = d_dst;
                unique case (d_opc)
                    K_HALT: begin
                        cnt_n = cnt_inc;
                        st_n  = ST_DONE;
                    end
                    K_ADD, K_SUB, K_MUL: begin
                        ram_addr = d_srca;
                        st_n     = ST_OPA;
                    end
                    K_JMP: begin
                        cnt_n = cnt_inc;
                        pc_n  = ($signed(result) <= 0) ? d_srca : d_srcb;
                        st_n  = (cnt_inc == BUDGET_C) ? ST_DONE : ST_FETCH;
                    end
                    default: begin
                        cnt_n = cnt_inc;
                        err_n = 1'b1;
                        st_n  = ST_DONE;
                    end
                endcase
            end
            ST_OPA: begin
                opa_n    = ram_rdata;
                ram_addr = k_srcb;
                st_n     = ST_OPB;
            end
            ST_OPB: begin
                ram_we    = 1'b1;
                ram_addr  = k_dst;
                ram_wdata = alu_y;
                res_n     = alu_y;
                pc_n      = pc + 1'b1;
                cnt_n     = cnt_inc;
                st_n      = (cnt_inc == BUDGET_C) ? ST_DONE : ST_FETCH;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign busy       = (st != ST_IDLE) && (st != ST_DONE);
    assign done       = (st == ST_DONE);
    assign host_rdata = ram_rdata;

    // R9: the executed-instruction count never passes the budget
    a_r9_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        op_count <= BUDGET_C);

    // R8: the error flag is only ever seen while stopped
    a_r8_err_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (st == ST_DONE));

    // R2: while running, only write-back drives the memory write enable
    a_r2_no_host_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && busy) |-> (st == ST_OPB));

    // R5: write-back moves the program counter on by one
    a_r5_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPB && cnt_inc != BUDGET_C) |=> (pc == $past(pc) + 1'b1));

    // R5: the result register holds the value written back to memory
    a_r5_result_is_written: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPB) |=> (result == $past(ram_wdata)));

    // R6: jump target follows the sign of the result register
    a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DECODE && d_opc == K_JMP && cnt_inc != BUDGET_C) |=>
        (pc == (($signed($past(result)) <= 0) ? $past(d_srca) : $past(d_srcb))));

    // R7: a stopped core stays stopped until the next start
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !start) |=> (st == ST_DONE));

endmodule

// File: tb/sim_tri_addr_cpu.sv
module sim_tri_addr_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  start_addr = '0;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, done, err;
    logic [31:0] result;
    logic [5:0]  op_count;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    tri_addr_cpu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .done(done), .err(err),
        .result(result), .op_count(op_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // R3 word layout: opcode 31:27, src1 26:18, src2 17:9, dst 8:0
    function automatic logic [31:0] enc(input int op, input int a, input int b, input int d);
        return {op[4:0], a[8:0], b[8:0], d[8:0]};
    endfunction

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a[8:0]; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a[8:0];
        @(negedge clk);
        v = host_rdata;
    endtask

    task automatic run(input int sa, output int cyc);
        @(negedge clk);
        start = 1'b1; start_addr = sa[8:0];
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            1: return a + b;
            2: return a - b;
            default: return a * b;
        endcase
    endfunction

    task automatic countdown(input int n, input int exp_ops, input logic [31:0] exp_left);
        logic [31:0] v;
        int cyc;
        wr(50, n); wr(51, 1); wr(60, 32'h5A5A_0001);
        wr(0, enc(2, 50, 51, 50));
        wr(1, enc(4, 2, 0, 60));
        wr(2, enc(0, 0, 0, 0));
        run(0, cyc);
        chk("R9 done", {31'd0, done}, 32'd1);
        chk("R9 op_count", {26'd0, op_count}, exp_ops);
        chk("R9 err clear", {31'd0, err}, 32'd0);
        rd(50, v);
        chk("R5 countdown memory", v, exp_left);
        chk("R5 countdown result", result, exp_left);
        rd(60, v);
        chk("R6 jump dst untouched", v, 32'h5A5A_0001);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] vals [8];
        logic [31:0] v, e;
        int cyc;
        vals[0] = 32'd0;          vals[1] = 32'd1;
        vals[2] = 32'hFFFF_FFFF;  vals[3] = 32'd7;
        vals[4] = 32'hFFFF_FFFB;  vals[5] = 32'h7FFF_FFFF;
        vals[6] = 32'h8000_0000;  vals[7] = 32'd12345;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 result", result, 32'd0);
        chk("R1 op_count", {26'd0, op_count}, 32'd0);

        // R2 host write and readback
        for (int i = 0; i < 8; i++) wr(400 + i, vals[i] ^ 32'h1357_9BDF);
        for (int i = 0; i < 8; i++) begin
            rd(400 + i, v);
            chk("R2 host readback", v, vals[i] ^ 32'h1357_9BDF);
        end

        // R3 R5 R10 arithmetic sweep, fields at their extremes
        for (int op = 1; op <= 3; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    wr(511, vals[i]); wr(256, vals[j]); wr(255, 32'hDEAD_BEEF);
                    wr(0, enc(op, 511, 256, 255));
                    wr(1, enc(0, 0, 0, 0));
                    run(0, cyc);
                    e = ref_alu(op, vals[i], vals[j]);
                    rd(255, v);
                    chk("R3 R5 arith memory", v, e);
                    chk("R5 arith result", result, e);
                    chk("R7 op_count", {26'd0, op_count}, 32'd2);
                    chk("R10 arith+halt cycles", cyc, 32'd6);
                end
            end
        end

        // R6 jump direction from the sign of the result
        for (int i = 0; i < 8; i++) begin
            wr(100, vals[i]); wr(101, 0); wr(110, 111); wr(111, 222);
            wr(300, 0); wr(301, 32'hC0FF_EE00);
            wr(10, enc(1, 100, 101, 102));
            wr(11, enc(4, 20, 30, 301));
            wr(20, enc(1, 110, 101, 300)); wr(21, enc(0, 0, 0, 0));
            wr(30, enc(1, 111, 101, 300)); wr(31, enc(0, 0, 0, 0));
            run(10, cyc);
            e = ($signed(vals[i]) <= 0) ? 32'd111 : 32'd222;
            chk("R6 jump path result", result, e);
            rd(300, v);
            chk("R6 jump path memory", v, e);
            rd(301, v);
            chk("R6 jump writes nothing", v, 32'hC0FF_EE00);
            chk("R10 add+jump+add+halt cycles", cyc, 32'd12);
            chk("R9 op_count jump program", {26'd0, op_count}, 32'd4);
        end

        // R7 R10 bare halt
        wr(7, enc(0, 5, 6, 7));
        run(7, cyc);
        chk("R7 halt done", {31'd0, done}, 32'd1);
        chk("R7 halt busy", {31'd0, busy}, 32'd0);
        chk("R10 halt cycles", cyc, 32'd2);

        // R9 countdown loops below, at and beyond the budget
        countdown(5, 11, 0);
        countdown(19, 39, 0);
        countdown(20, 40, 0);
        countdown(30, 40, 10);

        // R8 undefined opcodes, then R4 restart clears the error
        for (int op = 5; op < 32; op++) begin
            wr(0, enc(op, 1, 2, 3));
            run(0, cyc);
            chk("R8 undefined err", {31'd0, err}, 32'd1);
            chk("R8 undefined done", {31'd0, done}, 32'd1);
            chk("R8 undefined op_count", {26'd0, op_count}, 32'd1);
            chk("R10 undefined cycles", cyc, 32'd2);
        end
        wr(5, enc(0, 0, 0, 0));
        run(5, cyc);
        chk("R4 restart clears err", {31'd0, err}, 32'd0);
        chk("R4 restart count", {26'd0, op_count}, 32'd1);
        chk("R4 restart clears result", result, 32'd0);

        // R2 host writes while busy are dropped
        wr(420, 32'hAAAA_0000);
        wr(50, 5); wr(51, 1);
        wr(0, enc(2, 50, 51, 50)); wr(1, enc(4, 2, 0, 60)); wr(2, enc(0, 0, 0, 0));
        @(negedge clk);
        start = 1'b1; start_addr = 9'd0;
        @(negedge clk);
        start = 1'b0;
        chk("R4 busy after start", {31'd0, busy}, 32'd1);
        host_we = 1'b1; host_addr = 9'd420; host_wdata = 32'h5555_5555;
        repeat (10) @(negedge clk);
        host_we = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        rd(420, v);
        chk("R2 busy write dropped", v, 32'hAAAA_0000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule